// File: doc/BRIEF.md
# Two-Level Inclusive MESI Snoop Sequencer

This block resolves one memory-bus snoop against a second-level cache line and the first-level CPU cache line that it encloses. Both levels hold MESI state for the same address. A snoop arrives with the current state of each level and two qualifiers. The first qualifier asks for invalidation. The second marks a requester that will not cache the line. The block works out the final state of both levels. It also issues the CPU-bus and memory-bus actions that the snoop needs, as single-cycle strobes, in a fixed order.

A request is taken only while the block is idle. The block latches the request and spends one cycle deciding. If the second-level line is Modified, it inquires the first level and waits for a response. If the first-level copy was Modified, it collects the first-level writeback. It then drives the memory-bus snoop writeback. On an invalidating snoop of a valid line, it sends a back-invalidate on the CPU bus. Last, it raises a done pulse, and both next-state outputs are valid during that cycle. Tag lookup, data movement and bus handshakes are handled elsewhere.

Top module: `snp_unit`

## Requirements
- R1: When the second-level state is Invalid (00), no strobe other than done is issued, and both next states are Invalid (00).
- R2: An invalidating snoop (snpInv=1) ends with both levels Invalid. A back-invalidate strobe is issued whenever the second-level line was valid, including when the first-level line is Invalid.
- R3: A non-invalidating snoop moves a valid second-level line to Shared (01). The exception is a Modified (11) line with snpNoCache=1, which ends Exclusive (10).
- R4: A Modified second-level line always produces exactly one memory-bus snoop writeback strobe, whatever the qualifiers are.
- R5: An inquire strobe is issued only when the second-level line is Modified. A non-invalidating snoop of an Exclusive or Shared line issues no CPU-bus or memory-bus strobe.
- R6: After an inquire, the block waits for l1Resp. If the first-level line was Modified, an l1WbStb pulse follows, and it comes before memWbStb. Strobe order is inquire, first-level writeback, memory writeback, back-invalidate.
- R7: snpNoCache has no effect when snpInv=1.
- R8: On a non-invalidating snoop of a valid second-level line, a first-level line in Modified or Exclusive becomes Shared. A first-level line in Shared or Invalid keeps its state.
- R9: A request is accepted only while snpReady=1. snpValid pulses during a busy sequence are ignored. Exactly one done pulse follows the last action strobe, and snpReady returns high the next cycle.
- R10: States are encoded I=00, S=01, E=10, M=11. Every strobe lasts one cycle, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snpValid | input | 1 | Snoop request, taken when snpReady is high |
| l2State | input | 2 | Second-level line state at request |
| l1State | input | 2 | First-level line state at request |
| snpInv | input | 1 | Invalidating snoop qualifier |
| snpNoCache | input | 1 | Non-caching requester qualifier |
| l1Resp | input | 1 | First-level response to an inquire |
| snpReady | output | 1 | Block idle and able to accept a request |
| inqStb | output | 1 | CPU-bus inquire strobe |
| binvStb | output | 1 | CPU-bus back-invalidate strobe |
| l1WbStb | output | 1 | First-level writeback collected on CPU bus |
| memWbStb | output | 1 | Memory-bus snoop writeback strobe |
| donePulse | output | 1 | Sequence finished; next states valid |
| l2Next | output | 2 | Final second-level state |
| l1Next | output | 2 | Final first-level state |

## Verification
The hardest path to reach is the full sequence. It needs a Modified line at both levels under an invalidating snoop, and the first-level response must arrive several cycles late. All four action strobes then appear in order, with a long wait state in between. The bench reaches it with a responder inside the snoop task: it counts cycles from the observed inquire before it pulses l1Resp. In the same run, the bench pokes snpValid and changes the state inputs in the middle of the sequence. This shows that the latched request and the final states are not affected.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11} mesi_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic inq;
    logic l1wb;
    logic memwb;
    logic binv;
    logic done;
  } ctl_stb_t;

  // decision flags from datapath to control
  typedef struct packed {
    logic l2Mod;
    logic l1Mod;
    logic needBinv;
  } dp_flag_t;
endpackage

// File: rtl/snp_datapath.sv
module snp_datapath
  import snp_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  ctl_stb_t       stb,
  input  logic [1:0]     l2In,
  input  logic [1:0]     l1In,
  input  logic           invIn,
  input  logic           ncIn,
  output dp_flag_t       flags,
  output logic [1:0]     l2Next,
  output logic [1:0]     l1Next,
  output logic           inqStb,
  output logic           binvStb,
  output logic           l1WbStb,
  output logic           memWbStb,
  output logic           donePulse
);
  mesi_t l2Q, l1Q;
  logic  invQ, ncQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      l2Q  <= ST_I;
      l1Q  <= ST_I;
      invQ <= 1'b0;
      ncQ  <= 1'b0;
    end else if (stb.capture) begin
      l2Q  <= mesi_t'(l2In);
      l1Q  <= mesi_t'(l1In);
      invQ <= invIn;
      ncQ  <= ncIn;
    end
  end

  always_comb begin
    flags.l2Mod    = (l2Q == ST_M);
    flags.l1Mod    = (l1Q == ST_M);
    flags.needBinv = invQ && (l2Q != ST_I);
  end

  // final second-level state
  always_comb begin
    if (l2Q == ST_I || invQ)          l2Next = ST_I;
    else if (l2Q == ST_M && ncQ)      l2Next = ST_E;
    else                              l2Next = ST_S;
  end

  // final first-level state
  always_comb begin
    if (l2Q == ST_I || invQ)               l1Next = ST_I;
    else if (l1Q == ST_M || l1Q == ST_E)   l1Next = ST_S;
    else                                   l1Next = l1Q;
  end

  assign inqStb    = stb.inq;
  assign binvStb   = stb.binv;
  assign l1WbStb   = stb.l1wb;
  assign memWbStb  = stb.memwb;
  assign donePulse = stb.done;
endmodule

// File: rtl/snp_control.sv
module snp_control
  import snp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     snpValid,
  input  logic     l1Resp,
  input  dp_flag_t flags,
  output ctl_stb_t stb,
  output logic     ready
);
  typedef enum logic [2:0] {
    C_IDLE, C_EVAL, C_INQ, C_WAIT, C_L1WB, C_MEMWB, C_BINV, C_DONE
  } ctl_st_t;

  ctl_st_t st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= C_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    unique case (st)
      C_IDLE:  if (snpValid) stNext = C_EVAL;
      C_EVAL: begin
        if (flags.l2Mod)         stNext = C_INQ;
        else if (flags.needBinv) stNext = C_BINV;
        else                     stNext = C_DONE;
      end
      C_INQ:   stNext = C_WAIT;
      C_WAIT:  if (l1Resp) stNext = flags.l1Mod ? C_L1WB : C_MEMWB;
      C_L1WB:  stNext = C_MEMWB;
      C_MEMWB: stNext = flags.needBinv ? C_BINV : C_DONE;
      C_BINV:  stNext = C_DONE;
      C_DONE:  stNext = C_IDLE;
      default: stNext = C_IDLE;
    endcase
  end

  always_comb begin
    stb.capture = (st == C_IDLE) && snpValid;
    stb.inq     = (st == C_INQ);
    stb.l1wb    = (st == C_L1WB);
    stb.memwb   = (st == C_MEMWB);
    stb.binv    = (st == C_BINV);
    stb.done    = (st == C_DONE);
  end

  assign ready = (st == C_IDLE);
endmodule

// File: rtl/snp_unit.sv
module snp_unit
  import snp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       snpValid,
  input  logic [1:0] l2State,
  input  logic [1:0] l1State,
  input  logic       snpInv,
  input  logic       snpNoCache,
  input  logic       l1Resp,
  output logic       snpReady,
  output logic       inqStb,
  output logic       binvStb,
  output logic       l1WbStb,
  output logic       memWbStb,
  output logic       donePulse,
  output logic [1:0] l2Next,
  output logic [1:0] l1Next
);
  ctl_stb_t stb;
  dp_flag_t flags;

  snp_control u_ctl (
    .clk(clk), .rstN(rstN), .snpValid(snpValid), .l1Resp(l1Resp),
    .flags(flags), .stb(stb), .ready(snpReady)
  );

  snp_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .l2In(l2State), .l1In(l1State), .invIn(snpInv), .ncIn(snpNoCache),
    .flags(flags), .l2Next(l2Next), .l1Next(l1Next),
    .inqStb(inqStb), .binvStb(binvStb), .l1WbStb(l1WbStb),
    .memWbStb(memWbStb), .donePulse(donePulse)
  );
endmodule

// File: rtl/snp_unit_chk.sv
module snp_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       snpValid,
  input logic [1:0] l2State,
  input logic       snpInv,
  input logic       snpReady,
  input logic       inqStb,
  input logic       binvStb,
  input logic       l1WbStb,
  input logic       memWbStb,
  input logic       donePulse,
  input logic [1:0] l2Next,
  input logic [1:0] l1Next
);
  logic [1:0] shL2;
  logic       shInv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shL2  <= 2'b00;
      shInv <= 1'b0;
    end else if (snpValid && snpReady) begin
      shL2  <= l2State;
      shInv <= snpInv;
    end
  end

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inqStb, binvStb, l1WbStb, memWbStb, donePulse}));
  a_r10_inq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    inqStb |=> !inqStb);
  a_r5_inq_only_mod: assert property (@(posedge clk) disable iff (!rstN)
    inqStb |-> shL2 == 2'b11);
  a_r4_memwb_only_mod: assert property (@(posedge clk) disable iff (!rstN)
    memWbStb |-> shL2 == 2'b11);
  a_r6_l1wb_before_memwb: assert property (@(posedge clk) disable iff (!rstN)
    l1WbStb |=> memWbStb);
  a_r1_invalid_final: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && shL2 == 2'b00) |-> (l2Next == 2'b00 && l1Next == 2'b00));
  a_r2_inv_final: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && shInv) |-> (l2Next == 2'b00 && l1Next == 2'b00));
  a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> snpReady);
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (snpReady && !snpValid) |=> snpReady);
endmodule

bind snp_unit snp_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .snpValid(snpValid), .l2State(l2State),
  .snpInv(snpInv), .snpReady(snpReady), .inqStb(inqStb), .binvStb(binvStb),
  .l1WbStb(l1WbStb), .memWbStb(memWbStb), .donePulse(donePulse),
  .l2Next(l2Next), .l1Next(l1Next)
);

// File: tb/sim_snp_unit.sv
module sim_snp_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       snpValid = 1'b0;
  logic [1:0] l2State = 2'b00;
  logic [1:0] l1State = 2'b00;
  logic       snpInv = 1'b0;
  logic       snpNoCache = 1'b0;
  logic       l1Resp = 1'b0;
  logic       snpReady, inqStb, binvStb, l1WbStb, memWbStb, donePulse;
  logic [1:0] l2Next, l1Next;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  localparam logic [1:0] I = 2'b00, S = 2'b01, E = 2'b10, M = 2'b11;
  localparam logic [2:0] EV_INQ = 3'd1, EV_L1WB = 3'd2, EV_MEMWB = 3'd3, EV_BINV = 3'd4;

  always #4 clk = ~clk;  // 125 MHz

  snp_unit u0 (
    .clk(clk), .rstN(rstN), .snpValid(snpValid), .l2State(l2State),
    .l1State(l1State), .snpInv(snpInv), .snpNoCache(snpNoCache),
    .l1Resp(l1Resp), .snpReady(snpReady), .inqStb(inqStb),
    .binvStb(binvStb), .l1WbStb(l1WbStb), .memWbStb(memWbStb),
    .donePulse(donePulse), .l2Next(l2Next), .l1Next(l1Next)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expectations from the requirements
  function automatic logic [11:0] expSeq(logic [1:0] l2, logic [1:0] l1, bit inv);
    logic [11:0] s = '0;
    if (l2 == M) begin
      s = {s[8:0], EV_INQ};
      if (l1 == M) s = {s[8:0], EV_L1WB};
      s = {s[8:0], EV_MEMWB};
    end
    if (inv && l2 != I) s = {s[8:0], EV_BINV};
    return s;
  endfunction

  function automatic logic [1:0] expL2(logic [1:0] l2, bit inv, bit nc);
    if (l2 == I || inv) return I;
    if (l2 == M && nc) return E;
    return S;
  endfunction

  function automatic logic [1:0] expL1(logic [1:0] l2, logic [1:0] l1, bit inv);
    if (l2 == I || inv) return I;
    if (l1 == M || l1 == E) return S;
    return l1;
  endfunction

  // one snoop: drive, respond to inquire after respDelay cycles, record strobes
  task automatic doSnoop(input logic [1:0] l2, input logic [1:0] l1, input bit inv,
                         input bit nc, input int respDelay, input bit poke, input string req);
    logic [11:0] seq = '0;
    int cnt = -1;
    int cyc = 0;
    bit seenDone = 0;
    @(negedge clk);
    l2State = l2; l1State = l1; snpInv = inv; snpNoCache = nc; snpValid = 1'b1;
    @(negedge clk);
    snpValid = 1'b0;
    while (!seenDone && cyc < 50) begin
      l1Resp = 1'b0;
      if (poke && cyc == 1) begin
        snpValid = 1'b1; l2State = ~l2; l1State = ~l1; snpInv = ~inv; snpNoCache = ~nc;
      end else if (poke && cyc == 2) begin
        snpValid = 1'b0;
      end
      if (inqStb) begin seq = {seq[8:0], EV_INQ}; cnt = respDelay; end
      if (l1WbStb)  seq = {seq[8:0], EV_L1WB};
      if (memWbStb) seq = {seq[8:0], EV_MEMWB};
      if (binvStb)  seq = {seq[8:0], EV_BINV};
      if (cnt == 0) begin l1Resp = 1'b1; cnt = -1; end
      else if (cnt > 0) cnt--;
      if (donePulse) begin
        seenDone = 1;
        check(l2Next == expL2(l2, inv, nc), {req, " l2Next"}, l2Next, expL2(l2, inv, nc));
        check(l1Next == expL1(l2, l1, inv), {req, " l1Next"}, l1Next, expL1(l2, l1, inv));
        check(seq == expSeq(l2, l1, inv), {req, " strobe order"}, seq, expSeq(l2, l1, inv));
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    snpValid = 1'b0; l1Resp = 1'b0;
    check(seenDone, {req, " done seen"}, seenDone, 1);
    @(negedge clk);
    check(snpReady && !donePulse, {req, " R9 ready after single done"}, {snpReady, donePulse}, 2'b10);
  endtask

  task automatic t_reset();
    check(snpReady == 1'b1, "R9 reset ready", snpReady, 1);
    check({inqStb, binvStb, l1WbStb, memWbStb, donePulse} == 5'b0, "R10 reset strobes",
          {inqStb, binvStb, l1WbStb, memWbStb, donePulse}, 0);
  endtask

  task automatic t_invalid_line();
    for (int k = 0; k < 4; k++)
      doSnoop(I, I, k[0], k[1], 1, 0, "R1 invalid line");
  endtask

  task automatic t_invalidating();
    doSnoop(S, I, 1, 0, 1, 0, "R2 binv with L1 invalid");
    doSnoop(E, E, 1, 0, 1, 0, "R2 E inv");
    doSnoop(M, S, 1, 0, 2, 0, "R2 R4 M inv");
    doSnoop(M, M, 1, 1, 1, 0, "R7 nocache ignored under inv");
    doSnoop(S, S, 1, 1, 1, 0, "R7 nocache ignored S");
  endtask

  task automatic t_share();
    doSnoop(E, E, 0, 0, 1, 0, "R3 R8 E to S");
    doSnoop(E, I, 0, 1, 1, 0, "R5 E nocache quiet");
    doSnoop(S, S, 0, 0, 1, 0, "R5 R8 S stays");
    doSnoop(M, E, 0, 0, 1, 0, "R4 R8 M share");
    doSnoop(M, I, 0, 1, 1, 0, "R3 M nocache to E");
    doSnoop(M, M, 0, 1, 3, 0, "R6 R3 L1 writeback");
  endtask

  task automatic t_sweep();
    for (int a = 1; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int q = 0; q < 4; q++)
          if (b <= a || a == 3)
            doSnoop(a[1:0], b[1:0], q[0], q[1], 1 + (b % 2), 0, "R10 sweep");
  endtask

  task automatic t_busy_slow();
    doSnoop(M, M, 1, 0, 6, 1, "R6 R9 slow inquire with poke");
    doSnoop(E, E, 0, 1, 1, 1, "R9 poke during quiet snoop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_invalid_line();
    t_invalidating();
    t_share();
    t_sweep();
    t_busy_slow();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule